// File: doc/BRIEF.md
# MDIO Management Command Controller

This block is a register-driven management master for Ethernet PHYs. Software first loads a 16-bit write value into the data register. It then writes the command register with a PHY address, a register address, an MDC divider threshold and one start bit, either read or write. The controller shifts a clause-22 management frame out on MDC and MDIO. While it does this, the start bit reads back as 1. When the last bit has gone out, the controller clears the start bit itself, and software polls for that.

For a read, the controller stops driving MDIO for the turnaround and data bits. It samples the PHY's reply on each rising MDC edge and stores the 16-bit result in its own field of the data register, apart from the write value. The divider threshold sits in the command register beside the address fields, so software writes it back unchanged with every command.

Top module: `mdio_cmd_ctrl`

## Requirements
- R1: After reset, MDC and the MDIO output enable are low and both registers read 0.
- R2: The command register holds the threshold in bits [7:0], the PHY address in [12:8], the register address in [17:13], the read start in [18] and the write start in [19]; its other bits read 0. Writing it (select 0) while idle with a start bit set begins a transfer. The start bit reads 1 until 128*(threshold+1) clocks after the accepting edge and then reads 0.
- R3: During a transfer MDC is low for threshold+1 clocks and then high for threshold+1 clocks, once per frame bit, starting low. MDC is low whenever the controller is idle.
- R4: The frame is 64 bits sent MSB first, each bit held for a full MDC period starting at a falling edge. It is 32 ones, then 01, then the opcode (10 read, 01 write), the PHY address, the register address, then 10 on a write, then 16 data bits.
- R5: On a read, the output enable is high for the first 46 bits and low for the last 18. MDIO is sampled on each rising MDC edge of the last 16 bits. The sampled word, first bit as MSB, appears in data register bits [31:16] when the start bit clears.
- R6: The data register (select 1) holds the write value in bits [15:0], readable at any time. Bits [31:16] change only when a read completes.
- R7: A command write while a transfer is in progress is ignored, the threshold and address fields included, even in the clock in which the transfer completes.
- R8: If both start bits are written as 1, a read is performed and only bit [18] reads back as set.
- R9: A command write with neither start bit set updates the threshold and address fields and starts no transfer.
- R10: The write value is captured when a write is accepted. A data register write during the transfer changes the readback but not the frame in flight.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the command register, 1 the data register |
| reg_wdata | input | 32 | Register write value |
| cmd_rdata | output | 32 | Command register readback |
| data_rdata | output | 32 | Data register readback |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
A command write can land in the same clock as the transfer completes: the start bit is still set before that edge and drops on it. The bench provokes this by counting clocks in its reference model. It issues a command with a new threshold, new addresses and a start bit in the final clock of a read. It then expects the start bit to read 0 on the next cycle, the old fields to remain and no new MDC activity. A data-register write arriving in the middle of a write frame is the second overlap, and it is judged by comparing every driven MDIO bit against the frame captured at the start.

// File: rtl/mdio_cmd_ctrl.sv
`timescale 1ns/1ps
module mdio_cmd_ctrl #(
  parameter int THR_W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic        reg_sel,
  input  logic [31:0] reg_wdata,
  output logic [31:0] cmd_rdata,
  output logic [31:0] data_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int FRAME_LEN = 64;
  localparam int IDX_W     = $clog2(FRAME_LEN);
  localparam logic [IDX_W-1:0] LAST_BIT    = IDX_W'(FRAME_LEN - 1);
  localparam logic [IDX_W-1:0] RELEASE_BIT = IDX_W'(46);
  localparam logic [IDX_W-1:0] DATA_BIT    = IDX_W'(48);

  logic [THR_W-1:0]     thr, cnt;
  logic [4:0]           phy_ad, reg_ad;
  logic                 rd_go, wr_go, mdc_q;
  logic [15:0]          wval, rval, cap;
  logic [FRAME_LEN-1:0] shreg;
  logic [IDX_W-1:0]     bit_idx;

  wire busy    = rd_go | wr_go;
  wire cmd_acc = reg_we & ~reg_sel & ~busy;
  wire new_rd  = reg_wdata[18];
  wire new_wr  = reg_wdata[19] & ~reg_wdata[18];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr <= '0; cnt <= '0; phy_ad <= '0; reg_ad <= '0;
      rd_go <= 1'b0; wr_go <= 1'b0; mdc_q <= 1'b0;
      wval <= '0; rval <= '0; cap <= '0; shreg <= '0; bit_idx <= '0;
    end else begin
      if (reg_we && reg_sel) wval <= reg_wdata[15:0];
      if (cmd_acc) begin
        thr     <= reg_wdata[THR_W-1:0];
        phy_ad  <= reg_wdata[12:8];
        reg_ad  <= reg_wdata[17:13];
        rd_go   <= new_rd;
        wr_go   <= new_wr;
        cnt     <= '0;
        mdc_q   <= 1'b0;
        bit_idx <= '0;
        shreg   <= {32'hFFFF_FFFF, 2'b01, new_rd ? 2'b10 : 2'b01,
                    reg_wdata[12:8], reg_wdata[17:13], 2'b10,
                    new_rd ? 16'h0000 : wval};
      end else if (busy) begin
        if (cnt == thr) begin
          cnt   <= '0;
          mdc_q <= ~mdc_q;
          if (!mdc_q) begin
            if (rd_go && bit_idx >= DATA_BIT) cap <= {cap[14:0], mdio_i};
          end else if (bit_idx == LAST_BIT) begin
            rd_go <= 1'b0;
            wr_go <= 1'b0;
            if (rd_go) rval <= cap;
          end else begin
            bit_idx <= bit_idx + 1'b1;
            shreg   <= {shreg[FRAME_LEN-2:0], 1'b0};
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assign cmd_rdata  = 32'(thr) | {12'd0, wr_go, rd_go, reg_ad, phy_ad, 8'd0};
  assign data_rdata = {rval, wval};
  assign mdc        = mdc_q;
  assign mdio_o     = shreg[FRAME_LEN-1];
  assign mdio_oe    = busy & ~(rd_go & (bit_idx >= RELEASE_BIT));

  p_mdc_idle_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);
  p_mdc_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mdc_q) |-> ($past(cnt) == $past(thr)));
  p_fields_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(thr) && $stable(phy_ad) && $stable(reg_ad)));
  p_rdata_on_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rval) |-> $fell(busy));
  p_one_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_go, wr_go}));
endmodule

// File: tb/mdio_cmd_ctrl_tb.sv
`timescale 1ns/1ps
module mdio_cmd_ctrl_tb;
  logic clk = 1'b0, rst_n = 1'b0, reg_we = 1'b0, reg_sel = 1'b0, mdio_i = 1'b1;
  logic [31:0] reg_wdata = '0;
  logic [31:0] cmd_rdata, data_rdata;
  logic mdc, mdio_o, mdio_oe;
  int n_chk = 0, n_err = 0;

  mdio_cmd_ctrl u_dut (.clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .cmd_rdata(cmd_rdata), .data_rdata(data_rdata),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i));

  always #2.5 clk = ~clk;

  int k = -1, m_thr = 0;
  logic [4:0] m_phy = '0, m_reg = '0;
  logic m_rdg = 1'b0, m_wrg = 1'b0, was_busy;
  logic [15:0] m_wdata = '0, m_rdata = '0;
  logic [63:0] m_frame = '0;

  function automatic logic [15:0] pv(logic [4:0] p, logic [4:0] r);
    return 16'hA53C ^ {p, r, 6'h2B};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      k = -1; m_thr = 0; m_phy = '0; m_reg = '0; m_rdg = 0; m_wrg = 0;
      m_wdata = '0; m_rdata = '0;
    end else begin
      was_busy = (k >= 0);
      if (k >= 0) begin
        k++;
        if (k == 128 * (m_thr + 1)) begin
          k = -1;
          if (m_rdg) m_rdata = pv(m_phy, m_reg);
          m_rdg = 0; m_wrg = 0;
        end
      end
      if (reg_we && reg_sel) m_wdata = reg_wdata[15:0];
      if (reg_we && !reg_sel && !was_busy) begin
        m_thr = int'(reg_wdata[7:0]);
        m_phy = reg_wdata[12:8];
        m_reg = reg_wdata[17:13];
        m_rdg = reg_wdata[18];
        m_wrg = reg_wdata[19] && !reg_wdata[18];
        if (m_rdg || m_wrg) begin
          k = 0;
          m_frame = {32'hFFFF_FFFF, 2'b01, m_rdg ? 2'b10 : 2'b01, m_phy, m_reg, 2'b10,
                     m_rdg ? 16'h0000 : m_wdata};
        end
      end
    end
  end

  always @(negedge clk) begin
    if (k >= 0 && m_rdg) begin
      automatic int b = k / (2 * (m_thr + 1));
      automatic logic [15:0] v = pv(m_phy, m_reg);
      if (b == 47) mdio_i <= 1'b0;
      else if (b >= 48) mdio_i <= v[63 - b];
      else mdio_i <= 1'b1;
    end else mdio_i <= 1'b1;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      automatic logic e_mdc = (k >= 0) ? logic'((k / (m_thr + 1)) % 2) : 1'b0;
      automatic int b = (k >= 0) ? k / (2 * (m_thr + 1)) : 0;
      automatic logic e_oe = (k >= 0) && (!m_rdg || b < 46);
      automatic logic [31:0] e_cmd = {12'd0, m_wrg, m_rdg, m_reg, m_phy, 8'(m_thr)};
      chk(mdc === e_mdc, "R3 mdc", 32'(mdc), 32'(e_mdc));
      chk(mdio_oe === e_oe, "R5 mdio_oe", 32'(mdio_oe), 32'(e_oe));
      chk(cmd_rdata === e_cmd, "R2 cmd_rdata", cmd_rdata, e_cmd);
      chk(data_rdata === {m_rdata, m_wdata}, "R6 data_rdata", data_rdata, {m_rdata, m_wdata});
      if (e_oe) chk(mdio_o === m_frame[63 - b], "R4 mdio_o", 32'(mdio_o), 32'(m_frame[63 - b]));
    end
  end

  task automatic wr_reg(input logic sel, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  function automatic logic [31:0] cmdw(int thr, logic [4:0] p, logic [4:0] r, logic rd, logic wr);
    return {12'd0, wr, rd, r, p, 8'(thr)};
  endfunction

  task automatic wait_idle();
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (cmd_rdata[19:18] == 2'b00) break;
    end
  endtask

  initial begin
    #(5ns * 150000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(mdc === 1'b0 && mdio_oe === 1'b0, "R1 pins idle", {mdc, mdio_oe}, 0);
    chk(cmd_rdata === 0 && data_rdata === 0, "R1 regs zero", cmd_rdata | data_rdata, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2/R4/R10: write transfer, data rewritten mid-frame
    wr_reg(1'b1, 32'h0000_1234);
    wr_reg(1'b0, cmdw(0, 5'h03, 5'h11, 1'b0, 1'b1));
    chk(cmd_rdata[19] === 1'b1, "R2 write start reads 1", cmd_rdata, 32'h1);
    wr_reg(1'b1, 32'h0000_FFFF);
    chk(data_rdata[15:0] === 16'hFFFF, "R10 readback updated", data_rdata, 32'hFFFF);
    wr_reg(1'b0, cmdw(9, 5'h1F, 5'h1F, 1'b1, 1'b0));
    chk(cmd_rdata === cmdw(0, 5'h03, 5'h11, 1'b0, 1'b1), "R7 busy write ignored",
        cmd_rdata, cmdw(0, 5'h03, 5'h11, 1'b0, 1'b1));
    wait_idle();
    chk(cmd_rdata[19:18] === 2'b00, "R2 start cleared", cmd_rdata, 0);
    chk(data_rdata[31:16] === 16'h0000, "R6 write leaves read field", data_rdata, 0);

    // R5/R7: read with threshold 2, command on the completing clock
    wr_reg(1'b0, cmdw(2, 5'h1F, 5'h00, 1'b1, 1'b0));
    while (k != 128 * 3 - 1) @(negedge clk);
    reg_we = 1'b1; reg_sel = 1'b0; reg_wdata = cmdw(5, 5'h02, 5'h04, 1'b0, 1'b1);
    @(negedge clk); reg_we = 1'b0;
    chk(cmd_rdata === cmdw(2, 5'h1F, 5'h00, 1'b0, 1'b0), "R7 write on done clock ignored",
        cmd_rdata, cmdw(2, 5'h1F, 5'h00, 1'b0, 1'b0));
    chk(data_rdata[31:16] === pv(5'h1F, 5'h00), "R5 read value", data_rdata[31:16], pv(5'h1F, 5'h00));
    repeat (10) @(negedge clk);
    chk(mdc === 1'b0, "R7 no transfer started", mdc, 0);

    // R8: both start bits
    wr_reg(1'b0, cmdw(1, 5'h0A, 5'h15, 1'b1, 1'b1));
    chk(cmd_rdata[19:18] === 2'b01, "R8 read chosen", cmd_rdata[19:18], 2'b01);
    wait_idle();
    chk(data_rdata[31:16] === pv(5'h0A, 5'h15), "R8 read value", data_rdata[31:16], pv(5'h0A, 5'h15));

    // R9: no start bit
    wr_reg(1'b0, cmdw(3, 5'h06, 5'h09, 1'b0, 1'b0));
    repeat (20) @(negedge clk);
    chk(cmd_rdata === cmdw(3, 5'h06, 5'h09, 1'b0, 1'b0) && mdc === 1'b0, "R9 fields only",
        cmd_rdata, cmdw(3, 5'h06, 5'h09, 1'b0, 1'b0));

    // R3: write with threshold 3
    wr_reg(1'b1, 32'h0000_C3A5);
    wr_reg(1'b0, cmdw(3, 5'h06, 5'h09, 1'b0, 1'b1));
    wait_idle();
    chk(cmd_rdata[19:18] === 2'b00 && mdc === 1'b0, "R3 idle after slow write", cmd_rdata, 0);

    repeat (5) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule